// File: doc/BRIEF.md
# Per-Channel ADC Gain-Offset Corrector

This block sits in the result path of a multiplexed analog-to-digital converter. Raw 12-bit samples arrive on one shared stream, one sample per clock at most. Each sample carries its channel number (up to 32 channels) and its prescaler setting. For every sample the block forms a coefficient-RAM address from the channel and the prescaler. It reads a gain, an offset and an enable flag from that address, and computes y = gain · x + offset. The result is rounded and clamped back to 12 bits, so that threshold and averaging logic further downstream sees calibrated values.

The corrected sample leaves with its own valid strobe, channel and prescaler tag, a fixed 14 clock cycles after the raw strobe. Samples pass through unchanged in three cases: when a global disable is raised (for example when the converter reference differs from the one the coefficients were characterised at), when the table entry's enable flag is clear, or when the saturated-input bypass option is set and the raw value is full scale. How the coefficients are computed and loaded into the RAM lies outside this block.

Top module: `adc_gain_offset_corr`

## Requirements
- R1: For an entry taking correction, cor_data = clamp(floor((raw_data · gain + 8192) / 16384) + offset). The gain is unsigned with 14 fractional bits (16384 = 1.0). The offset is a signed 16-bit integer.
- R2: coef_addr equals {raw_chan, raw_pre}, with the channel in the upper bits. It is driven combinationally from the inputs. The RAM answers on coef_rdata one clock later, with the word layout [32] enable, [31:16] gain, [15:0] offset.
- R3: A sample whose coefficient word has enable bit 32 clear leaves with cor_data equal to raw_data.
- R4: cal_disable is sampled together with each raw sample. A sample taken while it is high leaves unchanged, and neighbouring samples are still corrected.
- R5: If sat_bypass_en is high with a sample whose raw_data is 4095, the output is 4095 without correction. If sat_bypass_en is low, that sample is corrected like any other. A raw value of 4094 is always corrected.
- R6: A sample whose entry holds gain 16384 and offset 0 leaves with cor_data equal to raw_data.
- R7: A corrected value below 0 is output as 0, and a value above 4095 is output as 4095.
- R8: cor_valid is high for exactly one cycle, 14 clock cycles after the cycle in which raw_valid was high for that sample, and never without a matching input.
- R9: cor_chan and cor_pre equal the raw_chan and raw_pre of the sample that cor_data belongs to.
- R10: Samples may arrive on every consecutive cycle. Each one produces its own output, in order, with no stall.
- R11: During reset, cor_valid, cor_data, cor_chan and cor_pre are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| raw_valid | input | 1 | Raw sample strobe |
| raw_data | input | 12 | Raw unsigned converter result |
| raw_chan | input | 5 | Channel number of the raw sample |
| raw_pre | input | 3 | Prescaler setting of the raw sample |
| cal_disable | input | 1 | Global correction disable, taken with each sample |
| sat_bypass_en | input | 1 | Forward full-scale samples uncorrected |
| coef_addr | output | 8 | Coefficient RAM read address |
| coef_rdata | input | 33 | Coefficient word, one cycle after the address |
| cor_valid | output | 1 | Corrected sample strobe |
| cor_data | output | 12 | Corrected sample |
| cor_chan | output | 5 | Channel tag of the corrected sample |
| cor_pre | output | 3 | Prescaler tag of the corrected sample |

## Verification
The main function is driven with a back-to-back stream of samples. Each sample selects a different table entry: gains above, below and at one, and positive, negative and zero offsets. This separates real arithmetic from pass-through, and catches a wrong rounding or a swapped address field. The same stream places values that overflow and underflow the 12-bit range, and full-scale inputs with the bypass option both on and off, next to ordinary samples. This shows the clamp and the saturation rule act per sample. A disabled entry and a sample taken with the global disable raised sit between corrected neighbours, which proves that disable travels with its own sample. A lone sample then pins the exact output cycle, and the reset values are checked.

// File: rtl/calib_pkg.sv
package calib_pkg;

  localparam int DEF_DATA_W    = 12;
  localparam int DEF_CH_W      = 5;
  localparam int DEF_PS_W      = 3;
  localparam int DEF_GAIN_W    = 16;
  localparam int DEF_GAIN_FRAC = 14;
  localparam int DEF_OFF_W     = 16;
  localparam int DEF_LATENCY   = 14;

  // Why a sample takes the path it does; every value other than
  // PATH_CORR forwards the raw sample unchanged.
  typedef enum logic [1:0] {
    PATH_CORR       = 2'd0,
    PATH_ENTRY_OFF  = 2'd1,
    PATH_GLOBAL_OFF = 2'd2,
    PATH_SAT        = 2'd3
  } route_e;

endpackage

// File: rtl/corr_delay.sv
module corr_delay #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_vld,
  input  logic [WIDTH-1:0] in_data,
  output logic             out_vld,
  output logic [WIDTH-1:0] out_data
);

  generate
    if (DEPTH == 0) begin : g_wire
      assign out_vld  = in_vld;
      assign out_data = in_data;
    end else begin : g_pipe
      logic             vld_q [DEPTH];
      logic [WIDTH-1:0] dat_q [DEPTH];

      for (genvar i = 0; i < DEPTH; i++) begin : g_stage
        logic             vld_src;
        logic [WIDTH-1:0] dat_src;
        if (i == 0) begin : g_head
          assign vld_src = in_vld;
          assign dat_src = in_data;
        end else begin : g_body
          assign vld_src = vld_q[i-1];
          assign dat_src = dat_q[i-1];
        end

        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            vld_q[i] <= 1'b0;
            dat_q[i] <= '0;
          end else begin
            vld_q[i] <= vld_src;
            if (vld_src) dat_q[i] <= dat_src;
          end
        end
      end

      assign out_vld  = vld_q[DEPTH-1];
      assign out_data = dat_q[DEPTH-1];
    end
  endgenerate

endmodule

// File: rtl/corr_arith.sv
module corr_arith
  import calib_pkg::*;
#(
  parameter int DATA_W    = DEF_DATA_W,
  parameter int GAIN_W    = DEF_GAIN_W,
  parameter int GAIN_FRAC = DEF_GAIN_FRAC,
  parameter int OFF_W     = DEF_OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_vld,
  input  logic [DATA_W-1:0] in_x,
  input  logic [GAIN_W-1:0] in_gain,
  input  logic [OFF_W-1:0]  in_off,
  input  route_e            in_route,
  output logic              out_vld,
  output logic [DATA_W-1:0] out_y
);

  localparam int PROD_W = DATA_W + GAIN_W;
  localparam int RND_W  = PROD_W + 1;
  localparam int Q_W    = RND_W - GAIN_FRAC;
  localparam int SUM_W  = ((Q_W > OFF_W) ? Q_W : OFF_W) + 1;
  localparam logic [RND_W-1:0]  HALF     = RND_W'(1) << (GAIN_FRAC - 1);
  localparam logic [GAIN_W-1:0] GAIN_ONE = GAIN_W'(1) << GAIN_FRAC;

  // stage A: product
  logic              a_vld_q;
  logic [PROD_W-1:0] a_prod_q, a_prod_nxt;
  logic [DATA_W-1:0] a_x_q;
  logic [OFF_W-1:0]  a_off_q;
  route_e            a_route_q;

  // stage B: rounded, offset, clamped result
  logic              b_vld_q;
  logic [DATA_W-1:0] b_y_q, b_y_nxt;

  logic [RND_W-1:0]        rnd;
  logic [Q_W-1:0]          q;
  logic signed [SUM_W-1:0] sum;
  logic [DATA_W-1:0]       clamped;

  always_comb begin
    a_prod_nxt = PROD_W'(in_x) * PROD_W'(in_gain);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_vld_q   <= 1'b0;
      a_prod_q  <= '0;
      a_x_q     <= '0;
      a_off_q   <= '0;
      a_route_q <= PATH_CORR;
    end else begin
      a_vld_q <= in_vld;
      if (in_vld) begin
        a_prod_q  <= a_prod_nxt;
        a_x_q     <= in_x;
        a_off_q   <= in_off;
        a_route_q <= in_route;
      end
    end
  end

  always_comb begin
    rnd = {1'b0, a_prod_q} + HALF;
    q   = rnd[RND_W-1:GAIN_FRAC];
    sum = $signed({{(SUM_W-Q_W){1'b0}}, q}) +
          $signed({{(SUM_W-OFF_W){a_off_q[OFF_W-1]}}, a_off_q});
    if (sum[SUM_W-1])
      clamped = '0;
    else if (|sum[SUM_W-2:DATA_W])
      clamped = '1;
    else
      clamped = sum[DATA_W-1:0];
    b_y_nxt = (a_route_q == PATH_CORR) ? clamped : a_x_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      b_vld_q <= 1'b0;
      b_y_q   <= '0;
    end else begin
      b_vld_q <= a_vld_q;
      if (a_vld_q) b_y_q <= b_y_nxt;
    end
  end

  assign out_vld = b_vld_q;
  assign out_y   = b_y_q;

  AST_BYPASS_RAW: assert property (@(posedge clk) disable iff (!rst_n)
    (a_vld_q && a_route_q != PATH_CORR) |=> (b_y_q == $past(a_x_q))); // R3

  AST_SAT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && in_route == PATH_SAT) |-> ##2 (out_y == {DATA_W{1'b1}})); // R5

  AST_UNITY_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && in_route == PATH_CORR && in_gain == GAIN_ONE && in_off == '0)
    |-> ##2 (out_y == $past(in_x, 2))); // R6

endmodule

// File: rtl/adc_gain_offset_corr.sv
module adc_gain_offset_corr
  import calib_pkg::*;
#(
  parameter int DATA_W    = DEF_DATA_W,
  parameter int CH_W      = DEF_CH_W,
  parameter int PS_W      = DEF_PS_W,
  parameter int GAIN_W    = DEF_GAIN_W,
  parameter int GAIN_FRAC = DEF_GAIN_FRAC,
  parameter int OFF_W     = DEF_OFF_W,
  parameter int LATENCY   = DEF_LATENCY,
  localparam int ADDR_W   = CH_W + PS_W,
  localparam int COEF_W   = 1 + GAIN_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              raw_valid,
  input  logic [DATA_W-1:0] raw_data,
  input  logic [CH_W-1:0]   raw_chan,
  input  logic [PS_W-1:0]   raw_pre,
  input  logic              cal_disable,
  input  logic              sat_bypass_en,
  output logic [ADDR_W-1:0] coef_addr,
  input  logic [COEF_W-1:0] coef_rdata,
  output logic              cor_valid,
  output logic [DATA_W-1:0] cor_data,
  output logic [CH_W-1:0]   cor_chan,
  output logic [PS_W-1:0]   cor_pre
);

  localparam int TAG_W  = ADDR_W;
  localparam int ARITH  = 2;
  localparam int TAIL   = LATENCY - 1 - ARITH;
  localparam int CNT_W  = $clog2(LATENCY + 1) + 1;
  localparam logic [DATA_W-1:0] FULL = '1;

  // stage 1: capture the sample while the RAM read is in flight
  logic              s1_vld_q;
  logic [DATA_W-1:0] s1_x_q;
  logic [TAG_W-1:0]  s1_tag_q;
  logic              s1_dis_q;
  logic              s1_satb_q;

  logic              coef_en;
  logic [GAIN_W-1:0] coef_gain;
  logic [OFF_W-1:0]  coef_off;
  route_e            route;

  logic              ar_vld;
  logic [DATA_W-1:0] ar_y;
  logic              tg_vld;
  logic [TAG_W-1:0]  tg_tag;
  logic              tl_vld;
  logic [DATA_W+TAG_W-1:0] tl_data;

  assign coef_addr = {raw_chan, raw_pre};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_vld_q  <= 1'b0;
      s1_x_q    <= '0;
      s1_tag_q  <= '0;
      s1_dis_q  <= 1'b0;
      s1_satb_q <= 1'b0;
    end else begin
      s1_vld_q <= raw_valid;
      if (raw_valid) begin
        s1_x_q    <= raw_data;
        s1_tag_q  <= {raw_chan, raw_pre};
        s1_dis_q  <= cal_disable;
        s1_satb_q <= sat_bypass_en;
      end
    end
  end

  assign coef_en   = coef_rdata[COEF_W-1];
  assign coef_gain = coef_rdata[GAIN_W+OFF_W-1:OFF_W];
  assign coef_off  = coef_rdata[OFF_W-1:0];

  always_comb begin
    if (s1_dis_q)
      route = PATH_GLOBAL_OFF;
    else if (!coef_en)
      route = PATH_ENTRY_OFF;
    else if (s1_satb_q && s1_x_q == FULL)
      route = PATH_SAT;
    else
      route = PATH_CORR;
  end

  corr_arith #(
    .DATA_W(DATA_W), .GAIN_W(GAIN_W), .GAIN_FRAC(GAIN_FRAC), .OFF_W(OFF_W)
  ) u_arith (
    .clk(clk), .rst_n(rst_n),
    .in_vld(s1_vld_q), .in_x(s1_x_q), .in_gain(coef_gain),
    .in_off(coef_off), .in_route(route),
    .out_vld(ar_vld), .out_y(ar_y)
  );

  corr_delay #(.WIDTH(TAG_W), .DEPTH(ARITH)) u_tag_align (
    .clk(clk), .rst_n(rst_n),
    .in_vld(s1_vld_q), .in_data(s1_tag_q),
    .out_vld(tg_vld), .out_data(tg_tag)
  );

  corr_delay #(.WIDTH(DATA_W + TAG_W), .DEPTH(TAIL)) u_tail (
    .clk(clk), .rst_n(rst_n),
    .in_vld(ar_vld), .in_data({ar_y, tg_tag}),
    .out_vld(tl_vld), .out_data(tl_data)
  );

  assign cor_valid = tl_vld;
  assign cor_data  = tl_data[DATA_W+TAG_W-1:TAG_W];
  assign cor_chan  = tl_data[TAG_W-1:PS_W];
  assign cor_pre   = tl_data[PS_W-1:0];

  // samples accepted but not yet delivered
  logic [CNT_W-1:0] inflight_q, inflight_nxt;

  always_comb begin
    inflight_nxt = inflight_q + CNT_W'(raw_valid) - CNT_W'(cor_valid);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) inflight_q <= '0;
    else        inflight_q <= inflight_nxt;
  end

  AST_INFLIGHT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    inflight_q <= CNT_W'(LATENCY)); // R10

  AST_NO_ORPHAN_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    cor_valid |-> (inflight_q != '0)); // R8

  AST_TAG_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    tg_vld == ar_vld); // R9

endmodule

// File: tb/adc_gain_offset_corr_tb.sv
`timescale 1ns/1ps
module adc_gain_offset_corr_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        raw_valid;
  logic [11:0] raw_data;
  logic [4:0]  raw_chan;
  logic [2:0]  raw_pre;
  logic        cal_disable;
  logic        sat_bypass_en;
  logic [7:0]  coef_addr;
  logic [32:0] coef_rdata;
  logic        cor_valid;
  logic [11:0] cor_data;
  logic [4:0]  cor_chan;
  logic [2:0]  cor_pre;

  always #4 clk = ~clk;

  adc_gain_offset_corr u_dut (
    .clk(clk), .rst_n(rst_n), .raw_valid(raw_valid), .raw_data(raw_data),
    .raw_chan(raw_chan), .raw_pre(raw_pre), .cal_disable(cal_disable),
    .sat_bypass_en(sat_bypass_en), .coef_addr(coef_addr),
    .coef_rdata(coef_rdata), .cor_valid(cor_valid), .cor_data(cor_data),
    .cor_chan(cor_chan), .cor_pre(cor_pre)
  );

  // coefficient RAM model: registered read, word {en, gain, offset}
  logic [32:0] mem [256];
  always @(posedge clk) coef_rdata <= mem[coef_addr];

  int n_chk  = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  endtask

  function automatic logic [32:0] cw(input bit en, input int g, input int off);
    return {en, 16'(g), 16'(off)};
  endfunction

  function automatic logic [11:0] model(input logic [11:0] x, input logic [32:0] w,
                                        input bit satb, input bit dis);
    longint p;
    longint s;
    if (dis || !w[32] || (satb && x == 12'hFFF)) return x;
    p = longint'(x) * longint'(w[31:16]);
    s = (p + 8192) >>> 14;
    s = s + longint'($signed(w[15:0]));
    if (s < 0) return 12'd0;
    if (s > 4095) return 12'd4095;
    return s[11:0];
  endfunction

  function automatic string label(input logic [11:0] x, input logic [32:0] w,
                                  input bit satb, input bit dis);
    if (dis) return "R4 data";
    if (!w[32]) return "R3 data";
    if (satb && x == 12'hFFF) return "R5 data";
    if (w[31:16] == 16'd16384 && w[15:0] == 16'd0) return "R6 data";
    if (x == 12'hFFF || x == 12'hFFE) return "R5/R7 data";
    if (model(x, w, satb, dis) == 12'd0 || model(x, w, satb, dis) == 12'd4095)
      return "R7 data";
    return "R1 data";
  endfunction

  // fields: {chan[5], pre[3], x[12], sat_bypass[1], disable[1]}
  localparam int NV = 14;
  localparam logic [21:0] VEC [NV] = '{
    {5'd3,  3'd1, 12'd1000, 1'b0, 1'b0},  // R1 gain 1.25, offset -100
    {5'd7,  3'd0, 12'd2000, 1'b0, 1'b0},  // R1 gain 0.5, offset +50
    {5'd31, 3'd7, 12'd3000, 1'b0, 1'b0},  // R7 overflow clamps high
    {5'd0,  3'd2, 12'd100,  1'b0, 1'b0},  // R7 underflow clamps low
    {5'd5,  3'd3, 12'd1234, 1'b0, 1'b0},  // R3 entry disabled
    {5'd9,  3'd4, 12'd2345, 1'b0, 1'b0},  // R6 unity entry
    {5'd12, 3'd6, 12'd3333, 1'b0, 1'b0},  // R1 gain just under 1
    {5'd7,  3'd0, 12'd4095, 1'b1, 1'b0},  // R5 saturated, bypass on
    {5'd7,  3'd0, 12'd4095, 1'b0, 1'b0},  // R5 saturated, bypass off
    {5'd3,  3'd1, 12'd1000, 1'b0, 1'b1},  // R4 global disable
    {5'd31, 3'd7, 12'd4094, 1'b1, 1'b0},  // R5 not full scale
    {5'd12, 3'd6, 12'd0,    1'b0, 1'b0},  // R1 zero input
    {5'd3,  3'd1, 12'd4095, 1'b1, 1'b1},  // R4 disable with saturation
    {5'd31, 3'd7, 12'd1,    1'b0, 1'b0}   // R1 small input
  };

  task automatic drive(input logic [21:0] v);
    raw_valid     = 1'b1;
    raw_chan      = v[21:17];
    raw_pre       = v[16:14];
    raw_data      = v[13:2];
    sat_bypass_en = v[1];
    cal_disable   = v[0];
  endtask

  task automatic idle();
    raw_valid = 1'b0; raw_data = '0; raw_chan = '0; raw_pre = '0;
    cal_disable = 1'b0; sat_bypass_en = 1'b0;
  endtask

  task automatic check_out(input logic [21:0] v);
    logic [32:0] w;
    logic [11:0] e;
    w = mem[{v[21:17], v[16:14]}];
    e = model(v[13:2], w, v[1], v[0]);
    chk(cor_valid === 1'b1, "R8 valid", int'(cor_valid), 1);
    chk(cor_data === e, label(v[13:2], w, v[1], v[0]), int'(cor_data), int'(e));
    chk(cor_chan === v[21:17], "R9 chan", int'(cor_chan), int'(v[21:17]));
    chk(cor_pre === v[16:14], "R9 pre", int'(cor_pre), int'(v[16:14]));
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end

  initial begin
    for (int a = 0; a < 256; a++) mem[a] = cw(1'b1, 16384, 0);
    mem[{5'd3,  3'd1}] = cw(1'b1, 20480, -100);
    mem[{5'd7,  3'd0}] = cw(1'b1, 8192, 50);
    mem[{5'd31, 3'd7}] = cw(1'b1, 32768, 0);
    mem[{5'd0,  3'd2}] = cw(1'b1, 16384, -500);
    mem[{5'd5,  3'd3}] = cw(1'b0, 49152, 300);
    mem[{5'd9,  3'd4}] = cw(1'b1, 16384, 0);
    mem[{5'd12, 3'd6}] = cw(1'b1, 16367, 7);

    idle();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(cor_valid === 1'b0, "R11 valid in reset", int'(cor_valid), 0);
    chk(cor_data === 12'd0, "R11 data in reset", int'(cor_data), 0);
    chk(cor_chan === 5'd0 && cor_pre === 3'd0, "R11 tags in reset",
        int'({cor_chan, cor_pre}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // back-to-back stream: R10 throughput, outputs 14 cycles later
    for (int cyc = 0; cyc < NV + 16; cyc++) begin
      @(negedge clk);
      if (cyc >= 14 && cyc - 14 < NV)
        check_out(VEC[cyc - 14]);
      else
        chk(cor_valid === 1'b0, "R10 no output in gap", int'(cor_valid), 0);
      if (cyc < NV) begin
        drive(VEC[cyc]);
        #1;
        chk(coef_addr === {VEC[cyc][21:17], VEC[cyc][16:14]}, "R2 addr",
            int'(coef_addr), int'({VEC[cyc][21:17], VEC[cyc][16:14]}));
      end else begin
        idle();
      end
    end

    // lone sample: exact output cycle (R8)
    repeat (3) @(negedge clk);
    drive({5'd12, 3'd6, 12'd2000, 1'b0, 1'b0});
    for (int n = 1; n <= 16; n++) begin
      @(negedge clk);
      if (n == 1) idle();
      if (n == 14)
        check_out({5'd12, 3'd6, 12'd2000, 1'b0, 1'b0});
      else
        chk(cor_valid === 1'b0, "R8 valid outside slot", int'(cor_valid), 0);
    end

    finish_run();
  end

endmodule